// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a synchronous DRAM command interface. After a synchronous reset it runs the mandatory bring-up sequence on its own. First it holds a long quiet pause in which only no-operation commands go out. It then closes every bank, issues a fixed number of auto-refresh commands, and loads the mode register with a value chosen at build time. Clock enable and the data mask lines stay high for the whole time, and the bank address stays at zero.

Each wait is given in nanoseconds and turned into a whole number of clock cycles, rounded up, from a clock-period parameter. The gap between two steps is exactly that cycle count, so every minimum spacing is met with no slack. When the last wait after the mode-register load has run out, a done flag rises and stays high. From then on the sequencer only drives no-operation, and a normal traffic controller can take over the bus.

Top module: `sdram_init_seq`

Cycle counts used below are rounded up from nanoseconds: P = pause, RP = precharge wait, RC = refresh cycle, MRD = mode-load wait, each at least 1. Edge k is the k-th rising clock edge at which reset is already released. Command pins (cs_n, ras_n, cas_n, we_n) encode NOP = 0111, precharge = 0010, auto-refresh = 0001 and mode-register set = 0000.

## Requirements
- R1: While reset is low, and in the cycle after a reset edge, the pins show NOP (0111), the address and bank are zero, and done is low.
- R2: After reset is released, the pins show NOP after edges 1 to P-1.
- R3: After edge P a single precharge-all (0010) appears, with address bit 10 high, every other address bit low and bank zero.
- R4: The first auto-refresh appears after edge P+RP, with NOP on every edge in between.
- R5: Exactly eight auto-refresh commands (0001) appear, spaced RC edges apart, with address zero and NOP in between.
- R6: A mode-register set (0000) appears RC edges after the last refresh, carrying the mode-value parameter on the address bus and bank zero.
- R7: Done rises after edge P+RP+8·RC+MRD and stays high; while done is high and after it, only NOP is driven.
- R8: Clock enable and every data-mask bit are high in every cycle, including during reset.
- R9: A reset asserted part-way through the sequence aborts it, and the full sequence restarts from the pause once reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_cke | output | 1 | Clock enable, held high |
| mem_dqm | output | DQM_W | Data mask, held high |
| mem_ba | output | BA_W | Bank address, held zero |
| mem_addr | output | ADDR_W | Address bus; A10 is set for the precharge, and it carries the mode value during the mode load |
| init_done | output | 1 | High once the bring-up sequence has finished |

## Verification
The bench uses a 4000 ps clock period and a 400 ns pause, giving a 100-cycle pause in place of the 50,000 cycles of the default 200 µs. The precharge wait is 18 ns. It does not divide evenly by the period, so the rounding-up path sets RP to 5. The refresh cycle is 20 ns (RC = 5) and the mode-load wait is 8 ns (MRD = 2). With these values the full sequence, and a reset that cuts into the third refresh, both complete in a few hundred cycles. Every edge of both runs is compared with the command, address, bank, done, clock-enable and mask values that an independent timeline predicts.

// File: rtl/sdram_init_pkg.sv
// Shared types and helpers for the SDRAM bring-up sequencer.
// Assumes: delays are given in whole nanoseconds and the clock period in picoseconds.
package sdram_init_pkg;

    // Command requested by the step controller for the next cycle.
    typedef enum logic [1:0] {
        CMD_NOP = 2'd0,
        CMD_PRE = 2'd1,
        CMD_REF = 2'd2,
        CMD_MRS = 2'd3
    } init_cmd_e;

    // Progress of the bring-up sequence.
    typedef enum logic [2:0] {
        ST_PAUSE   = 3'd0,
        ST_REFRESH = 3'd1,
        ST_MODE    = 3'd2,
        ST_SETTLE  = 3'd3,
        ST_READY   = 3'd4
    } init_state_e;

    // Active-low command pin group, ordered cs, ras, cas, we.
    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_cmd_t;

    localparam pin_cmd_t PINS_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam pin_cmd_t PINS_PRE = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam pin_cmd_t PINS_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam pin_cmd_t PINS_MRS = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    // Converts nanoseconds to a cycle count, rounding up, never below one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period_ps);
        longint unsigned prod;
        longint unsigned cyc;
        prod = longint'(ns) * 64'd1000;
        cyc  = (prod + longint'(period_ps) - 64'd1) / longint'(period_ps);
        if (cyc < 64'd1) cyc = 64'd1;
        return int'(cyc);
    endfunction

    // Larger of two counts.
    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/init_wait_timer.sv
// Down-counter that spaces the bring-up steps.
// It starts at RESET_VAL after reset, counts toward zero, and reloads only when expired.
// Assumes: the controller loads only while the timer is expired.
module init_wait_timer #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned RESET_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] count_q;

    assign expired = (count_q == '0);

    // Reload on request, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= CNT_W'(RESET_VAL);
        end else if (load) begin
            count_q <= load_val;
        end else if (!expired) begin
            count_q <= count_q - 1'b1;
        end
    end

    // R4
    load_when_expired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> expired);

    // R5
    zero_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);

endmodule

// File: rtl/init_step_ctrl.sv
// Step controller: walks pause, precharge-all, refreshes, mode load, settle, ready.
// A step fires only when the wait timer has expired, and each step arms the next wait.
// Assumes: all cycle counts are at least 1 and fit in CNT_W bits.
module init_step_ctrl
    import sdram_init_pkg::*;
#(
    parameter int unsigned REFRESHES = 8,
    parameter int unsigned RP_CYC    = 5,
    parameter int unsigned RC_CYC    = 15,
    parameter int unsigned MRD_CYC   = 3,
    parameter int unsigned CNT_W     = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             expired,
    output logic             load,
    output logic [CNT_W-1:0] load_val,
    output init_cmd_e        issue,
    output logic             ready
);

    localparam int unsigned REF_W = $clog2(REFRESHES + 1);

    init_state_e      state_q, state_d;
    logic [REF_W-1:0] ref_left_q, ref_left_d;

    // Chooses the next command, the next wait, and the next state.
    always_comb begin
        load       = 1'b0;
        load_val   = '0;
        issue      = CMD_NOP;
        state_d    = state_q;
        ref_left_d = ref_left_q;
        if (expired) begin
            case (state_q)
                ST_PAUSE: begin
                    issue      = CMD_PRE;
                    load       = 1'b1;
                    load_val   = CNT_W'(RP_CYC - 1);
                    ref_left_d = REF_W'(REFRESHES);
                    state_d    = ST_REFRESH;
                end
                ST_REFRESH: begin
                    issue      = CMD_REF;
                    load       = 1'b1;
                    load_val   = CNT_W'(RC_CYC - 1);
                    ref_left_d = ref_left_q - 1'b1;
                    if (ref_left_q == REF_W'(1)) state_d = ST_MODE;
                end
                ST_MODE: begin
                    issue    = CMD_MRS;
                    load     = 1'b1;
                    load_val = CNT_W'(MRD_CYC - 1);
                    state_d  = ST_SETTLE;
                end
                ST_SETTLE: state_d = ST_READY;
                default: ;
            endcase
        end
    end

    // Holds the sequence state and the number of refreshes still owed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_PAUSE;
            ref_left_q <= REF_W'(REFRESHES);
        end else begin
            state_q    <= state_d;
            ref_left_q <= ref_left_d;
        end
    end

    assign ready = (state_q == ST_READY);

    // R5
    all_refreshes_before_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MODE) |-> (ref_left_q == '0));

    // R7
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READY) |=> (state_q == ST_READY));

endmodule

// File: rtl/init_pin_drive.sv
// Output register stage that turns a requested command into pin levels.
// The address carries A10 for the precharge-all and the mode value for the mode load.
// Assumes: ADDR_W is greater than AP_BIT.
module init_pin_drive
    import sdram_init_pkg::*;
#(
    parameter int unsigned ADDR_W     = 11,
    parameter int unsigned BA_W       = 2,
    parameter int unsigned DQM_W      = 4,
    parameter int unsigned AP_BIT     = 10,
    parameter logic [ADDR_W-1:0] MODE_VALUE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  init_cmd_e         issue,
    output pin_cmd_t          pins,
    output logic              cke,
    output logic [DQM_W-1:0]  dqm,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);

    localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

    pin_cmd_t          pins_d;
    logic [ADDR_W-1:0] addr_d;

    // Maps the requested command to its pin levels and address.
    always_comb begin
        case (issue)
            CMD_PRE: begin pins_d = PINS_PRE; addr_d = AP_MASK;    end
            CMD_REF: begin pins_d = PINS_REF; addr_d = '0;         end
            CMD_MRS: begin pins_d = PINS_MRS; addr_d = MODE_VALUE; end
            default: begin pins_d = PINS_NOP; addr_d = '0;         end
        endcase
    end

    // Registers every pin so the interface sees clean levels for a full cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins <= PINS_NOP;
            addr <= '0;
            ba   <= '0;
            cke  <= 1'b1;
            dqm  <= '1;
        end else begin
            pins <= pins_d;
            addr <= addr_d;
            ba   <= '0;
            cke  <= 1'b1;
            dqm  <= '1;
        end
    end

    // R3
    precharge_all_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pins == PINS_PRE) |-> addr[AP_BIT]);

endmodule

// File: rtl/sdram_init_seq.sv
// Top of the SDRAM bring-up sequencer.
// It converts the nanosecond delays into cycle counts and ties together the timer, the controller and the pin stage.
// Assumes: a free-running clock and a synchronous active-low reset.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 4000,
    parameter int unsigned T_PAUSE_NS    = 200000,
    parameter int unsigned T_RP_NS       = 18,
    parameter int unsigned T_RC_NS       = 60,
    parameter int unsigned T_MRD_NS      = 12,
    parameter int unsigned REFRESHES     = 8,
    parameter int unsigned ADDR_W        = 11,
    parameter int unsigned BA_W          = 2,
    parameter int unsigned DQM_W         = 4,
    parameter logic [ADDR_W-1:0] MODE_VALUE = 11'h032
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic              mem_cke,
    output logic [DQM_W-1:0]  mem_dqm,
    output logic [BA_W-1:0]   mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              init_done
);

    localparam int unsigned PAUSE_CYC = ns_to_cycles(T_PAUSE_NS, CLK_PERIOD_PS);
    localparam int unsigned RP_CYC    = ns_to_cycles(T_RP_NS, CLK_PERIOD_PS);
    localparam int unsigned RC_CYC    = ns_to_cycles(T_RC_NS, CLK_PERIOD_PS);
    localparam int unsigned MRD_CYC   = ns_to_cycles(T_MRD_NS, CLK_PERIOD_PS);
    localparam int unsigned MAX_CYC   = max2(max2(PAUSE_CYC, RP_CYC), max2(RC_CYC, MRD_CYC));
    localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

    logic             expired;
    logic             load;
    logic [CNT_W-1:0] load_val;
    init_cmd_e        issue;
    pin_cmd_t         pins;

    init_wait_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (PAUSE_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    init_step_ctrl #(
        .REFRESHES (REFRESHES),
        .RP_CYC    (RP_CYC),
        .RC_CYC    (RC_CYC),
        .MRD_CYC   (MRD_CYC),
        .CNT_W     (CNT_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .expired  (expired),
        .load     (load),
        .load_val (load_val),
        .issue    (issue),
        .ready    (init_done)
    );

    init_pin_drive #(
        .ADDR_W     (ADDR_W),
        .BA_W       (BA_W),
        .DQM_W      (DQM_W),
        .AP_BIT     (10),
        .MODE_VALUE (MODE_VALUE)
    ) u_drive (
        .clk   (clk),
        .rst_n (rst_n),
        .issue (issue),
        .pins  (pins),
        .cke   (mem_cke),
        .dqm   (mem_dqm),
        .ba    (mem_ba),
        .addr  (mem_addr)
    );

    assign mem_cs_n  = pins.cs_n;
    assign mem_ras_n = pins.ras_n;
    assign mem_cas_n = pins.cas_n;
    assign mem_we_n  = pins.we_n;

    // R7
    quiet_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (pins == PINS_NOP));

endmodule

// File: tb/sdram_init_seq_tb.sv
// Bench: a timeline model predicts every pin on every cycle, for one run cut short by reset and one full run.
module sdram_init_seq_tb;

    localparam int PER_PS   = 4000;
    localparam int PAUSE_NS = 400;
    localparam int RP_NS    = 18;
    localparam int RC_NS    = 20;
    localparam int MRD_NS   = 8;
    localparam logic [10:0] MODE = 11'h032;

    function automatic int cyc(input int ns);
        int c;
        c = (ns * 1000 + PER_PS - 1) / PER_PS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int P      = cyc(PAUSE_NS);
    localparam int RP     = cyc(RP_NS);
    localparam int RC     = cyc(RC_NS);
    localparam int MRD    = cyc(MRD_NS);
    localparam int T_REF0 = P + RP;
    localparam int T_MRS  = P + RP + 8 * RC;
    localparam int T_DONE = T_MRS + MRD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n, ras_n, cas_n, we_n, cke, done;
    logic [3:0]  dqm;
    logic [1:0]  ba;
    logic [10:0] addr;

    int  t = 0;
    bit  rst_seen = 1'b0;
    bit  started = 1'b0;
    bit  second = 1'b0;
    bit  finished = 1'b0;
    int  checks = 0;
    int  fails = 0;

    always #2 clk = ~clk;

    sdram_init_seq #(
        .CLK_PERIOD_PS (PER_PS),
        .T_PAUSE_NS    (PAUSE_NS),
        .T_RP_NS       (RP_NS),
        .T_RC_NS       (RC_NS),
        .T_MRD_NS      (MRD_NS),
        .MODE_VALUE    (MODE)
    ) u_dut (
        .clk (clk), .rst_n (rst_n),
        .mem_cs_n (cs_n), .mem_ras_n (ras_n), .mem_cas_n (cas_n), .mem_we_n (we_n),
        .mem_cke (cke), .mem_dqm (dqm), .mem_ba (ba), .mem_addr (addr),
        .init_done (done)
    );

    // Timeline: count edges since reset release, and keep the reset level used at that edge.
    always @(posedge clk) begin
        started  <= 1'b1;
        rst_seen <= rst_n;
        if (!rst_n) t <= 0;
        else        t <= t + 1;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0d actual=%0h expected=%0h", tag, t, act, exp);
        end
    endtask

    // Compare the design against the timeline on every falling edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            logic [3:0]  e_cmd;
            logic [10:0] e_addr;
            logic        e_done;
            string       tag;
            e_cmd = 4'b0111; e_addr = '0; e_done = 1'b0;
            if (!rst_seen) tag = "R1";
            else if (t < P) tag = "R2";
            else if (t == P) begin tag = "R3"; e_cmd = 4'b0010; e_addr = 11'h400; end
            else if (t < T_REF0) tag = "R4";
            else if (t < T_MRS) begin
                tag = "R5";
                if ((t - T_REF0) % RC == 0) e_cmd = 4'b0001;
            end
            else if (t == T_MRS) begin tag = "R6"; e_cmd = 4'b0000; e_addr = MODE; end
            else if (t < T_DONE) tag = "R6";
            else begin tag = "R7"; e_done = 1'b1; end
            if (second) tag = {"R9/", tag};
            chk({tag, " cmd"},  {28'd0, cs_n, ras_n, cas_n, we_n}, {28'd0, e_cmd});
            chk({tag, " addr"}, {21'd0, addr}, {21'd0, e_addr});
            chk({tag, " bank"}, {30'd0, ba}, 32'd0);
            chk({tag, " done"}, {31'd0, done}, {31'd0, e_done});
            chk("R8 cke/dqm", {27'd0, cke, dqm}, 32'h1F);
        end
    end

    // Stimulus: a reset cut into the third refresh, then a full run.
    initial begin
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (T_REF0 + 2 * RC + 1) @(negedge clk);
        rst_n = 1'b0;
        second = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (T_DONE + 20) @(negedge clk);
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (5000) @(posedge clk);
        finished = 1'b1;
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule